// File: doc/BRIEF.md
# Multiport Receive FIFO Read Port

This block is the host-facing read path of four receive FIFOs, one per network port. The host shares one 32-bit data bus and one clock across the four queues. A 2-bit port select names the queue, and two active-low enables qualify each read. A qualified read to a non-empty queue returns the head word in that cycle and removes it at the clock edge. The word comes with its stored end-of-frame flag and its active-low byte enables. A data-available output marks each cycle in which the returned word is real.

Each queue also drives a ready flag toward the host. The flag rises when the queue holds at least a programmable number of words. It also rises when the queue holds the closing word of a complete packet, even if that is below the threshold, so that short frames are not left waiting. A simple write port stands in for the receive MAC. It pushes data words into a selected queue and tags the last word of each packet.

Top module: `rx_fifo_read_port`

## Requirements
- R1: After reset every queue is empty. rd_valid_o is low, and each rdy_o bit is low whenever thresh_i is nonzero.
- R2: A word is removed only in a cycle where rif_en_ni and rd_en_ni are both 0. With either enable at 1, no queue changes and rd_valid_o is 0.
- R3: The select value k on rd_port_i and wr_port_i addresses queue k: 2'b00 is port 1 and 2'b11 is port 4, with bit 1 as the MSB. rdy_o bit k belongs to queue k.
- R4: Each queue returns words in write order and holds 32 words. A write to a full queue is dropped, even if a read of that queue happens in the same cycle.
- R5: rdy_o[k] is 1 when queue k holds at least thresh_i words. thresh_i is 6 bits wide and ranges from 0 to 32.
- R6: rdy_o[k] is also 1, at any fill level, while queue k holds a word written with wr_eof_i = 1. It falls once all such words have been read, unless the threshold still holds.
- R7: rd_eof_o carries the end-of-frame flag stored with the returned word. It is 1 on the last word of a packet.
- R8: While rif_en_ni is 1, the outputs are held in their idle state: rdy_o = 0, rd_data_o = 0, rd_eof_o = 0, rd_be_no = 4'b1111 and rd_valid_o = 0.
- R9: rd_be_no is active low, one bit per byte, with bit 0 for rd_data_o[7:0]. It returns the wr_be_ni value stored with the word.
- R10: rd_valid_o is 1 only in a read cycle whose selected queue is not empty. A read of an empty queue returns zero data, no end-of-frame flag and rd_be_no = 4'b1111, and it moves nothing.
- R11: A write and a read to the same queue in one cycle both take effect. When the word read and the word written are both end-of-frame words, the ready state stays in step with the packets held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for writes and reads |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Stand-in writer: push one word |
| wr_port_i | input | 2 | Queue written |
| wr_data_i | input | 32 | Word written |
| wr_be_ni | input | 4 | Active-low byte enables stored with the word |
| wr_eof_i | input | 1 | Word is the last of its packet |
| thresh_i | input | 6 | Ready threshold in words |
| rif_en_ni | input | 1 | Receive interface enable, active low |
| rd_en_ni | input | 1 | Read enable, active low |
| rd_port_i | input | 2 | Queue read |
| rd_data_o | output | 32 | Returned word |
| rd_eof_o | output | 1 | End-of-frame flag of the returned word |
| rd_be_no | output | 4 | Active-low byte enables of the returned word |
| rd_valid_o | output | 1 | Returned word is valid |
| rdy_o | output | 4 | Per-queue ready flags |

## Verification
A push from the writer and a pop by the host can hit the same queue in the same cycle. The hard case is when both words are end-of-frame, because the packet count must then stay the same. The bench provokes this with directed cycles on a queue that holds one packet, and also on a full queue, where the write must be dropped. Random traffic with a biased port choice adds many more such cycles. Each case is judged through the ready flag the following cycle and through the order and flags of the words read back, compared against a bench model of the four queues.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;
  localparam int unsigned NPORT_DEF = 4;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned DEPTH_DEF = 32;

  function automatic int unsigned word_w(input int unsigned dw);
    return dw + dw / 8 + 1;
  endfunction
endpackage

// File: rtl/rxrd_port_fifo.sv
module rxrd_port_fifo #(
  parameter int unsigned W       = 37,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned EOF_BIT = 32,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_word_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o,
  output logic          pkt_pend_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, pkt_q;
  logic          full, push_ok, pop_ok;
  logic          pkt_inc, pkt_dec;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign pkt_pend_o = (pkt_q != '0);
  assign pkt_inc = push_ok && push_word_i[EOF_BIT];
  assign pkt_dec = pop_ok && head_o[EOF_BIT];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      pkt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (pkt_inc && !pkt_dec)      pkt_q <= pkt_q + 1'b1;
      else if (pkt_dec && !pkt_inc) pkt_q <= pkt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rxrd_ready.sv
module rxrd_ready #(
  parameter int unsigned CW = 6
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          pkt_pend_i,
  input  logic          drive_i,
  output logic          rdy_o
);
  // threshold reached, or a whole packet waits below it
  assign rdy_o = drive_i && ((count_i >= thresh_i) || pkt_pend_i);
endmodule

// File: rtl/rxrd_read_mux.sv
module rxrd_read_mux #(
  parameter int unsigned NPORT = 4,
  parameter int unsigned W     = 37,
  parameter int unsigned BEW   = 4,
  localparam int unsigned PW   = $clog2(NPORT)
) (
  input  logic [W-1:0]     head_i [NPORT],
  input  logic [NPORT-1:0] empty_i,
  input  logic [PW-1:0]    sel_i,
  input  logic             rd_act_i,
  output logic [W-1:0]     word_o,
  output logic             valid_o,
  output logic [NPORT-1:0] pop_o
);
  always_comb begin
    valid_o = rd_act_i && !empty_i[sel_i];
    pop_o   = '0;
    // idle word: zero data and eof, byte enables inactive (high)
    word_o  = {{BEW{1'b1}}, {(W - BEW){1'b0}}};
    if (valid_o) begin
      pop_o[sel_i] = 1'b1;
      word_o       = head_i[sel_i];
    end
  end
endmodule

// File: rtl/rx_fifo_read_port.sv
module rx_fifo_read_port #(
  parameter int unsigned NPORT  = rxrd_pkg::NPORT_DEF,
  parameter int unsigned DATA_W = rxrd_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = rxrd_pkg::DEPTH_DEF,
  localparam int unsigned BEW   = DATA_W / 8,
  localparam int unsigned W     = rxrd_pkg::word_w(DATA_W),
  localparam int unsigned PW    = $clog2(NPORT),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PW-1:0]     wr_port_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BEW-1:0]    wr_be_ni,
  input  logic              wr_eof_i,
  input  logic [CW-1:0]     thresh_i,
  input  logic              rif_en_ni,
  input  logic              rd_en_ni,
  input  logic [PW-1:0]     rd_port_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_eof_o,
  output logic [BEW-1:0]    rd_be_no,
  output logic              rd_valid_o,
  output logic [NPORT-1:0]  rdy_o
);
  // word layout: {be_n, eof, data}
  localparam int unsigned EOF_BIT = DATA_W;

  logic [W-1:0]     wr_word;
  logic [W-1:0]     head [NPORT];
  logic [NPORT-1:0] empty, pkt_pend, pop;
  logic [CW-1:0]    count [NPORT];
  logic [W-1:0]     rd_word;
  logic             rd_act;

  assign wr_word = {wr_be_ni, wr_eof_i, wr_data_i};
  assign rd_act  = !rif_en_ni && !rd_en_ni;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rxrd_port_fifo #(.W(W), .DEPTH(DEPTH), .EOF_BIT(EOF_BIT)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (wr_en_i && (wr_port_i == PW'(p))),
      .push_word_i (wr_word),
      .pop_i       (pop[p]),
      .head_o      (head[p]),
      .empty_o     (empty[p]),
      .count_o     (count[p]),
      .pkt_pend_o  (pkt_pend[p])
    );

    rxrd_ready #(.CW(CW)) u_rdy (
      .count_i    (count[p]),
      .thresh_i   (thresh_i),
      .pkt_pend_i (pkt_pend[p]),
      .drive_i    (!rif_en_ni),
      .rdy_o      (rdy_o[p])
    );
  end

  rxrd_read_mux #(.NPORT(NPORT), .W(W), .BEW(BEW)) u_mux (
    .head_i   (head),
    .empty_i  (empty),
    .sel_i    (rd_port_i),
    .rd_act_i (rd_act),
    .word_o   (rd_word),
    .valid_o  (rd_valid_o),
    .pop_o    (pop)
  );

  assign rd_data_o = rd_word[DATA_W-1:0];
  assign rd_eof_o  = rd_word[EOF_BIT];
  assign rd_be_no  = rd_word[W-1 -: BEW];
endmodule

// File: rtl/rxrd_checker.sv
module rxrd_checker #(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = 2,
  parameter int unsigned BEW    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rif_en_ni,
  input logic              rd_en_ni,
  input logic [PW-1:0]     rd_port_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_eof_o,
  input logic [BEW-1:0]    rd_be_no,
  input logic              rd_valid_o,
  input logic [NPORT-1:0]  rdy_o
);
  a_r2_valid_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!rif_en_ni && !rd_en_ni));

  a_r8_idle_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rif_en_ni |-> (rdy_o == '0 && rd_data_o == '0 && !rd_eof_o && rd_be_no == '1));

  a_r10_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0 && !rd_eof_o && rd_be_no == '1));

  a_r6_eof_word_means_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_eof_o) |-> rdy_o[rd_port_i]);
endmodule

bind rx_fifo_read_port rxrd_checker #(
  .NPORT(NPORT), .DATA_W(DATA_W), .PW(PW), .BEW(BEW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rif_en_ni(rif_en_ni), .rd_en_ni(rd_en_ni),
  .rd_port_i(rd_port_i), .rd_data_o(rd_data_o), .rd_eof_o(rd_eof_o),
  .rd_be_no(rd_be_no), .rd_valid_o(rd_valid_o), .rdy_o(rdy_o)
);

// File: tb/tb_rx_fifo_read_port.sv
module tb_rx_fifo_read_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DEP = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_port_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  wr_be_ni = '1;
  logic        wr_eof_i = 1'b0;
  logic [5:0]  thresh_i = 6'd8;
  logic        rif_en_ni = 1'b1;
  logic        rd_en_ni = 1'b1;
  logic [1:0]  rd_port_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_eof_o;
  logic [3:0]  rd_be_no;
  logic        rd_valid_o;
  logic [3:0]  rdy_o;

  rx_fifo_read_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_port_i(wr_port_i),
    .wr_data_i(wr_data_i), .wr_be_ni(wr_be_ni), .wr_eof_i(wr_eof_i),
    .thresh_i(thresh_i), .rif_en_ni(rif_en_ni), .rd_en_ni(rd_en_ni),
    .rd_port_i(rd_port_i), .rd_data_o(rd_data_o), .rd_eof_o(rd_eof_o),
    .rd_be_no(rd_be_no), .rd_valid_o(rd_valid_o), .rdy_o(rdy_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // bench model
  logic [31:0] m_data [NP][DEP];
  logic        m_eof  [NP][DEP];
  logic [3:0]  m_be   [NP][DEP];
  int m_head [NP];
  int m_cnt  [NP];
  int m_pkt  [NP];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int unsigned seed_v;

  function automatic bit exp_rdy(input int p, input logic rif_n, input int thr);
    return !rif_n && ((m_cnt[p] >= thr) || (m_pkt[p] > 0));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_head[p] = 0; m_cnt[p] = 0; m_pkt[p] = 0;
    end
  endtask

  // one cycle: drive at negedge, check before posedge, update model
  task automatic step(input logic we, input logic [1:0] wp, input logic [31:0] wd,
                      input logic [3:0] wbe, input logic weof, input logic rif_n,
                      input logic rde_n, input logic [1:0] rp, input string tag);
    bit act, val;
    int h;
    string t;
    @(negedge clk);
    wr_en_i = we; wr_port_i = wp; wr_data_i = wd; wr_be_ni = wbe; wr_eof_i = weof;
    rif_en_ni = rif_n; rd_en_ni = rde_n; rd_port_i = rp;
    #1;
    act = !rif_n && !rde_n;
    val = act && (m_cnt[rp] > 0);
    h = m_head[rp];
    t = (tag != "") ? tag : (rif_n ? "R8" : "");
    chk((t != "") ? t : (act ? "R10" : "R2"), {31'd0, rd_valid_o}, {31'd0, val});
    chk((t != "") ? t : "R4", rd_data_o, val ? m_data[rp][h] : 32'd0);
    chk((t != "") ? t : "R7", {31'd0, rd_eof_o}, {31'd0, val ? m_eof[rp][h] : 1'b0});
    chk((t != "") ? t : "R9", {28'd0, rd_be_no}, {28'd0, val ? m_be[rp][h] : 4'hf});
    for (int p = 0; p < NP; p++)
      chk((t != "") ? t : "R5", {31'd0, rdy_o[p]}, {31'd0, exp_rdy(p, rif_n, int'(thresh_i))});
    // model update: full check before the pop, as the rule states
    if (we && m_cnt[wp] < DEP) begin
      int wi = (m_head[wp] + m_cnt[wp]) % DEP;
      m_data[wp][wi] = wd; m_eof[wp][wi] = weof; m_be[wp][wi] = wbe;
      m_cnt[wp]++;
      if (weof) m_pkt[wp]++;
    end
    if (val) begin
      if (m_eof[rp][h]) m_pkt[rp]--;
      m_head[rp] = (h + 1) % DEP;
      m_cnt[rp]--;
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [31:0] d, input logic e, input string tag);
    step(1'b1, p, d, 4'h0, e, 1'b0, 1'b1, 2'd0, tag);
  endtask

  task automatic rd(input logic [1:0] p, input string tag);
    step(1'b0, 2'd0, 32'd0, 4'hf, 1'b0, 1'b0, 1'b0, p, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    seed_v = 32'd1234;
    void'($urandom(seed_v));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset state
    step(1'b0, 2'd0, 32'd0, 4'hf, 1'b0, 1'b0, 1'b1, 2'd0, "R1");
    rd(2'd2, "R1");

    // R3: each select addresses its own queue
    for (int p = 0; p < NP; p++) wr(2'(p), 32'hA000_0000 + 32'(p), 1'b0, "R3");
    for (int p = NP - 1; p >= 0; p--) rd(2'(p), "R3");

    // R2: enables not both low do not pop
    wr(2'd1, 32'h1111_2222, 1'b0, "");
    step(1'b0, 2'd0, 32'd0, 4'hf, 1'b0, 1'b0, 1'b1, 2'd1, "R2");
    step(1'b0, 2'd0, 32'd0, 4'hf, 1'b0, 1'b1, 1'b0, 2'd1, "R8");
    rd(2'd1, "R2");

    // R9: byte enables kept with word
    step(1'b1, 2'd3, 32'hCAFE_0001, 4'b1000, 1'b1, 1'b0, 1'b1, 2'd0, "R9");
    rd(2'd3, "R9");

    // R6: short packet below threshold makes ready
    thresh_i = 6'd20;
    wr(2'd0, 32'h5, 1'b0, "R6");
    wr(2'd0, 32'h6, 1'b0, "R6");
    wr(2'd0, 32'h7, 1'b1, "R6");
    rd(2'd0, "R6"); rd(2'd0, "R6"); rd(2'd0, "R6"); rd(2'd0, "R6");

    // R5: threshold boundary
    thresh_i = 6'd4;
    for (int i = 0; i < 5; i++) wr(2'd2, 32'h100 + 32'(i), 1'b0, "R5");
    for (int i = 0; i < 5; i++) rd(2'd2, "R5");

    // R11: same-queue write and read, both end-of-frame
    thresh_i = 6'd30;
    wr(2'd1, 32'hE0F0_0001, 1'b1, "R11");
    step(1'b1, 2'd1, 32'hE0F0_0002, 4'h0, 1'b1, 1'b0, 1'b0, 2'd1, "R11");
    rd(2'd1, "R11");
    rd(2'd1, "R11");

    // R4: fill to 32, drop extra, including read+write while full
    for (int i = 0; i < DEP; i++) wr(2'd3, 32'h3000 + 32'(i), 1'b0, "R4");
    wr(2'd3, 32'hDEAD_DEAD, 1'b0, "R4");
    step(1'b1, 2'd3, 32'hBEEF_BEEF, 4'h0, 1'b1, 1'b0, 1'b0, 2'd3, "R4");
    for (int i = 0; i < DEP; i++) rd(2'd3, "R4");

    // R10: empty read
    rd(2'd3, "R10");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] wp = 2'($urandom_range(0, 3));
      logic [1:0] rp = ($urandom_range(0, 3) == 0) ? wp : 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) thresh_i = 6'($urandom_range(0, 32));
      step($urandom_range(0, 99) < 55, wp, $urandom, 4'($urandom),
           $urandom_range(0, 5) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 99) < 50, rp, "");
    end

    finish_run();
  end
endmodule